// File: doc/BRIEF.md
# Late-Write Burst SRAM Controller

This block models, cycle by cycle, a pipelined burst SRAM with a late-write data path and a small behavioural storage array. Each rising clock edge it decodes a command from two control pins, an active-low load strobe and a read/write select. The four commands are idle, read load, write load and continue. A third pin chooses one data word per clock (single rate) or a pair of words per clock (double rate). The pair is presented as a rise word and a fall word on two parallel buses, because true dual-edge clocking is out of scope.

A 2-bit burst sequencer walks the low address bits from the loaded start offset. Mode pin `ilv` picks the order: high gives an XOR interleave, low gives a linear count modulo 4. The upper address bits do not change during a burst. A write supplies its data one clock after its address. The newest write beat is held in pending registers and reaches the array only when the next write beat arrives. A read whose address matches a pending word takes its data from the pending registers. Two flags report bus misuse. One flags a write load issued too soon after read traffic. The other flags a continue issued while no burst is active.

The sequencer is a five-state machine. IDLE means no burst. RD_SDR and RD_DDR are read bursts at single and double rate. WR_SDR and WR_DDR are the matching write bursts. The transitions are: NOP goes to IDLE from any state. Read load goes to RD_SDR or RD_DDR, picked by `sdr`. Write load goes to WR_SDR or WR_DDR in the same way. Continue stays in the current burst state and advances the offset. Continue in IDLE stays in IDLE and raises the protocol flag.

Top module: `lw_burst_sram`

## Requirements
- R1: Commands are decoded as `ld_n`=1,`rw`=0 idle; `ld_n`=0,`rw`=1 read load; `ld_n`=0,`rw`=0 write load; `ld_n`=1,`rw`=1 continue. `sdr`=1 selects single rate and `sdr`=0 double rate; `sdr` is sampled only on a load.
- R2: For a read (load or continue) registered at edge t, the read data and `q_en_rise` appear after edge t+1. At double rate, `q_en_fall` and the second word on `q_fall` appear after the same edge. `q_en_fall` is never high without `q_en_rise`.
- R3: For a write (load or continue) registered at edge t, the data on `wd_rise` is captured at edge t+1. At double rate, `wd_fall` is also captured at edge t+1 as the second word.
- R4: A read returns the most recently written data for its address. This holds whether that data is still in the pending registers (bypass) or already committed to the array. Pending data is committed only when the next write beat is captured.
- R5: The word offset for beat i of a burst is start XOR i when `ilv`=1, and (start + i) mod 4 when `ilv`=0. Start is `addr[1:0]` at the load. `addr[AW-1:2]` is kept from the load.
- R6: A continue advances the beat index by 1 at single rate and by 2 at double rate. The index wraps modulo 4 when more continues follow.
- R7: `q_en_rise` and `q_en_fall` are low after the edge that follows a cycle holding an idle, a write or a rejected continue.
- R8: A write load with fewer than two non-read cycles since the last read cycle raises `turn_err` for one cycle, after the edge that registers it. The write is still performed.
- R9: A continue while the state is IDLE raises `proto_err` for one cycle, after the edge that registers it. It causes no read or write and leaves the state IDLE.
- R10: After reset the state is IDLE, both output enables and both flags are low, and no pending write is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Load strobe, low starts a new burst |
| rw | input | 1 | Read (1) or write (0); with `ld_n`=1, 1 means continue |
| sdr | input | 1 | 1 single rate, 0 double rate (sampled on load) |
| ilv | input | 1 | Burst order: 1 XOR interleave, 0 linear |
| addr | input | AW | Word address, sampled on load |
| wd_rise | input | DW | Write data, first word of a beat |
| wd_fall | input | DW | Write data, second word at double rate |
| q_rise | output | DW | Read data, first word |
| q_fall | output | DW | Read data, second word at double rate |
| q_en_rise | output | 1 | `q_rise` is driven (low means high-impedance) |
| q_en_fall | output | 1 | `q_fall` is driven |
| turn_err | output | 1 | Read-to-write turnaround violation pulse |
| proto_err | output | 1 | Continue without an active burst |

## Verification
Every cycle, the assertions check the read-to-output latency and the double-rate enable pairing. They also check that idles and writes leave the data buses undriven, and that the turnaround and stray-continue flags rise after the patterns that must raise them. The values on the data buses can only be shown by the bench scenarios. These cover the interleaved and linear orders from every start offset, wrap-around after extra continues, and bypass from the pending registers against reads from the committed array. The bench compares every returned word with a model memory that is updated the moment write data is driven.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SDR,
        ST_RD_DDR,
        ST_WR_SDR,
        ST_WR_DDR
    } burst_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_READ,
        CMD_WRITE,
        CMD_CONT
    } bus_cmd_t;

    function automatic bus_cmd_t decode_cmd(input logic load_n, input logic rd);
        if (load_n) return rd ? CMD_CONT : CMD_NOP;
        return rd ? CMD_READ : CMD_WRITE;
    endfunction

    function automatic logic [1:0] beat_offset(input logic interleave,
                                               input logic [1:0] start,
                                               input logic [1:0] idx);
        return interleave ? (start ^ idx) : (start + idx);
    endfunction

endpackage

// File: rtl/lw_burst_seq.sv
module lw_burst_seq
    import lw_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic          sdr,
    input  logic          ilv,
    input  logic [AW-1:0] addr,
    output logic          stg_rd,
    output logic          stg_wr,
    output logic          stg_ddr,
    output logic [AW-1:0] stg_a0,
    output logic [AW-1:0] stg_a1,
    output logic          rd_beat,
    output logic          wr_load,
    output logic          proto_err
);
    localparam int HW = AW - 2;

    burst_state_t state, nxt;
    bus_cmd_t     cmd;
    logic [HW-1:0] hi_q, hi_n;
    logic [1:0]    start_q, start_n, cnt_q, cnt_n, cnt_n1;
    logic          ddr_now, wr_beat, ddr_beat;

    always_comb begin
        cmd     = decode_cmd(ld_n, rw);
        nxt     = state;
        hi_n    = hi_q;
        start_n = start_q;
        cnt_n   = cnt_q;
        ddr_now = (state == ST_RD_DDR) || (state == ST_WR_DDR);
        unique case (cmd)
            CMD_NOP:   nxt = ST_IDLE;
            CMD_READ: begin
                nxt     = sdr ? ST_RD_SDR : ST_RD_DDR;
                hi_n    = addr[AW-1:2];
                start_n = addr[1:0];
                cnt_n   = 2'd0;
            end
            CMD_WRITE: begin
                nxt     = sdr ? ST_WR_SDR : ST_WR_DDR;
                hi_n    = addr[AW-1:2];
                start_n = addr[1:0];
                cnt_n   = 2'd0;
            end
            CMD_CONT: begin
                if (state != ST_IDLE) cnt_n = cnt_q + (ddr_now ? 2'd2 : 2'd1);
            end
        endcase
        cnt_n1   = cnt_n + 2'd1;
        rd_beat  = (nxt == ST_RD_SDR) || (nxt == ST_RD_DDR);
        wr_beat  = (nxt == ST_WR_SDR) || (nxt == ST_WR_DDR);
        ddr_beat = (nxt == ST_RD_DDR) || (nxt == ST_WR_DDR);
        wr_load  = (cmd == CMD_WRITE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hi_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            state   <= nxt;
            hi_q    <= hi_n;
            start_q <= start_n;
            cnt_q   <= cnt_n;
        end
    end

    // registered outputs: beat stage and protocol flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_rd    <= 1'b0;
            stg_wr    <= 1'b0;
            stg_ddr   <= 1'b0;
            stg_a0    <= '0;
            stg_a1    <= '0;
            proto_err <= 1'b0;
        end else begin
            stg_rd    <= rd_beat;
            stg_wr    <= wr_beat;
            stg_ddr   <= ddr_beat;
            stg_a0    <= {hi_n, beat_offset(ilv, start_n, cnt_n)};
            stg_a1    <= {hi_n, beat_offset(ilv, start_n, cnt_n1)};
            proto_err <= (cmd == CMD_CONT) && (state == ST_IDLE);
        end
    end

endmodule

// File: rtl/lw_turn_guard.sv
module lw_turn_guard #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_beat,
    input  logic wr_load,
    output logic turn_err
);
    localparam int GW = $clog2(GAP + 1);
    localparam logic [GW-1:0] GMAX = GW'(GAP);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q    <= GMAX;
            turn_err <= 1'b0;
        end else begin
            turn_err <= wr_load && (gap_q < GMAX);
            if (rd_beat)            gap_q <= '0;
            else if (gap_q < GMAX)  gap_q <= gap_q + 1'b1;
        end
    end

endmodule

// File: rtl/lw_store.sv
module lw_store #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stg_rd,
    input  logic          stg_wr,
    input  logic          stg_ddr,
    input  logic [AW-1:0] stg_a0,
    input  logic [AW-1:0] stg_a1,
    input  logic [DW-1:0] wd_rise,
    input  logic [DW-1:0] wd_fall,
    output logic [DW-1:0] q_rise,
    output logic [DW-1:0] q_fall,
    output logic          q_en_rise,
    output logic          q_en_fall
);
    localparam int DEPTH = 1 << AW;
    localparam int LANES = 2;

    logic [DW-1:0] mem [DEPTH];
    logic [LANES-1:0] pv;
    logic [AW-1:0]    pa [LANES];
    logic [DW-1:0]    pd [LANES];
    logic [AW-1:0]    la [LANES];

    assign la[0] = stg_a0;
    assign la[1] = stg_a1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW-1:0] val;
        always_comb begin
            val = mem[la[g]];
            for (int p = 0; p < LANES; p++)
                if (pv[p] && (pa[p] == la[g])) val = pd[p];
        end
    end

    // commit of the previous pending beat when a new write beat lands
    always_ff @(posedge clk) begin
        if (stg_wr)
            for (int p = 0; p < LANES; p++)
                if (pv[p]) mem[pa[p]] <= pd[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv <= '0;
            for (int p = 0; p < LANES; p++) begin
                pa[p] <= '0;
                pd[p] <= '0;
            end
        end else if (stg_wr) begin
            pv    <= {stg_ddr, 1'b1};
            pa[0] <= stg_a0;
            pa[1] <= stg_a1;
            pd[0] <= wd_rise;
            pd[1] <= wd_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_rise    <= '0;
            q_fall    <= '0;
            q_en_rise <= 1'b0;
            q_en_fall <= 1'b0;
        end else begin
            q_en_rise <= stg_rd;
            q_en_fall <= stg_rd && stg_ddr;
            q_rise    <= stg_rd ? g_lane[0].val : '0;
            q_fall    <= (stg_rd && stg_ddr) ? g_lane[1].val : '0;
        end
    end

endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram #(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter int TURN_GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic          sdr,
    input  logic          ilv,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd_rise,
    input  logic [DW-1:0] wd_fall,
    output logic [DW-1:0] q_rise,
    output logic [DW-1:0] q_fall,
    output logic          q_en_rise,
    output logic          q_en_fall,
    output logic          turn_err,
    output logic          proto_err
);
    logic          stg_rd, stg_wr, stg_ddr, rd_beat, wr_load;
    logic [AW-1:0] stg_a0, stg_a1;

    lw_burst_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .sdr(sdr), .ilv(ilv),
        .addr(addr), .stg_rd(stg_rd), .stg_wr(stg_wr), .stg_ddr(stg_ddr),
        .stg_a0(stg_a0), .stg_a1(stg_a1), .rd_beat(rd_beat), .wr_load(wr_load),
        .proto_err(proto_err)
    );

    lw_turn_guard #(.GAP(TURN_GAP)) u_turn (
        .clk(clk), .rst_n(rst_n), .rd_beat(rd_beat), .wr_load(wr_load),
        .turn_err(turn_err)
    );

    lw_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .stg_rd(stg_rd), .stg_wr(stg_wr),
        .stg_ddr(stg_ddr), .stg_a0(stg_a0), .stg_a1(stg_a1),
        .wd_rise(wd_rise), .wd_fall(wd_fall), .q_rise(q_rise), .q_fall(q_fall),
        .q_en_rise(q_en_rise), .q_en_fall(q_en_fall)
    );

endmodule

// File: rtl/lw_burst_sram_chk.sv
module lw_burst_sram_chk #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_n,
    input logic          rw,
    input logic          sdr,
    input logic          q_en_rise,
    input logic          q_en_fall,
    input logic          turn_err,
    input logic          proto_err
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && rw) |=> ##1 q_en_rise);

    a_r2_ddr_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && rw && !sdr) |=> ##1 q_en_fall);

    a_r2_fall_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        q_en_fall |-> q_en_rise);

    a_r7_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !rw) |=> ##1 (!q_en_rise && !q_en_fall));

    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !rw) |=> ##1 !q_en_rise);

    a_r8_turn_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ld_n && !rw && $past(!ld_n && rw)) |=> turn_err);

    a_r9_stray_cont: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ld_n && rw && $past(ld_n && !rw)) |=> proto_err);

    a_r9_load_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n) |=> !proto_err);

endmodule

bind lw_burst_sram lw_burst_sram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .sdr(sdr),
    .q_en_rise(q_en_rise), .q_en_fall(q_en_fall),
    .turn_err(turn_err), .proto_err(proto_err)
);

// File: tb/sim_lw_burst_sram.sv
`timescale 1ns/1ps
module sim_lw_burst_sram;
    localparam int AW = 6, DW = 8, DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ld_n = 1'b1, rw = 1'b0, sdr = 1'b1, ilv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wd_rise = '0, wd_fall = '0;
    logic [DW-1:0] q_rise, q_fall;
    logic q_en_rise, q_en_fall, turn_err, proto_err;

    lw_burst_sram #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .sdr(sdr), .ilv(ilv),
        .addr(addr), .wd_rise(wd_rise), .wd_fall(wd_fall), .q_rise(q_rise),
        .q_fall(q_fall), .q_en_rise(q_en_rise), .q_en_fall(q_en_fall),
        .turn_err(turn_err), .proto_err(proto_err)
    );

    always #2.5 clk = ~clk;

    int nvec = 0, nbad = 0;
    logic [DW-1:0] model [DEPTH];
    int m_kind = 0, m_hi = 0, m_start = 0, m_cnt = 0, m_gap = 2, wseq = 0;
    bit m_ddr = 0;
    bit wp_v = 0, wp_ddr = 0;
    int wp_a0 = 0, wp_a1 = 0;
    bit xo_en = 0, xo_ddr = 0, xn_en = 0, xn_ddr = 0, xe_turn = 0, xe_proto = 0;
    logic [DW-1:0] xo_r = '0, xo_f = '0, xn_r = '0, xn_f = '0;
    string xo_tag = "R10", xn_tag = "R10";

    function automatic int boff(int st, int idx);
        return ilv ? ((st ^ idx) & 3) : ((st + idx) & 3);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    // one clock: check outputs, drive a command, advance the reference model
    task automatic step(input bit l, input bit r, input bit s, input int a, input string tag);
        int a0, a1;
        check({xo_tag, " rise enable"}, 32'(q_en_rise), 32'(xo_en));
        check({xo_tag, " fall enable (R2)"}, 32'(q_en_fall), 32'(xo_en && xo_ddr));
        if (xo_en) begin
            check({xo_tag, " rise data"}, 32'(q_rise), 32'(xo_r));
            if (xo_ddr) check({xo_tag, " fall data"}, 32'(q_fall), 32'(xo_f));
        end
        check("R8 turnaround flag", 32'(turn_err), 32'(xe_turn));
        check("R9 protocol flag", 32'(proto_err), 32'(xe_proto));

        ld_n = l; rw = r; sdr = s; addr = a[AW-1:0];
        if (wp_v) begin
            wd_rise = DW'(wseq * 37 + 11);
            wd_fall = DW'(wseq * 53 + 5);
            wseq++;
            model[wp_a0] = wd_rise;
            if (wp_ddr) model[wp_a1] = wd_fall;
        end else begin
            wd_rise = DW'(8'hA5 ^ wseq);
            wd_fall = ~wd_rise;
        end

        xe_turn = 0; xe_proto = 0;
        if (l && !r) m_kind = 0;
        else if (!l) begin
            if (!r && m_gap < 2) xe_turn = 1;
            m_kind = r ? 1 : 2; m_ddr = !s;
            m_hi = a >> 2; m_start = a & 3; m_cnt = 0;
        end else begin
            if (m_kind == 0) xe_proto = 1;
            else m_cnt = (m_cnt + (m_ddr ? 2 : 1)) & 3;
        end
        a0 = m_hi * 4 + boff(m_start, m_cnt);
        a1 = m_hi * 4 + boff(m_start, m_cnt + 1);

        xo_en = xn_en; xo_ddr = xn_ddr; xo_r = xn_r; xo_f = xn_f; xo_tag = xn_tag;
        xn_en = (m_kind == 1); xn_ddr = m_ddr;
        xn_r = model[a0]; xn_f = model[a1]; xn_tag = tag;
        wp_v = (m_kind == 2); wp_ddr = m_ddr; wp_a0 = a0; wp_a1 = a1;
        m_gap = (m_kind == 1) ? 0 : ((m_gap < 2) ? m_gap + 1 : 2);
        @(negedge clk);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 1, 0, "R7");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R10 rise enable after reset", 32'(q_en_rise), 0);
        check("R10 fall enable after reset", 32'(q_en_fall), 0);
        check("R10 turnaround flag after reset", 32'(turn_err), 0);
        check("R10 protocol flag after reset", 32'(proto_err), 0);

        // R1 and R3: single-rate write load to every address, back to back
        for (int a = 0; a < DEPTH; a++) step(0, 0, 1, a, "R3");
        nop(2);

        // R5 and R6: single-rate bursts, every start offset, both orders
        for (int m = 0; m < 2; m++) begin
            ilv = m[0];
            for (int hi = 0; hi < DEPTH / 4; hi++)
                for (int st = 0; st < 4; st++) begin
                    step(0, 1, 1, hi * 4 + st, "R5");
                    for (int c = 0; c < 3; c++) step(1, 1, 1, 0, "R6");
                end
        end

        // R2 and R6: double-rate bursts with one extra continue that wraps
        for (int m = 0; m < 2; m++) begin
            ilv = m[0];
            for (int hi = 0; hi < DEPTH / 4; hi += 3)
                for (int st = 0; st < 4; st++) begin
                    step(0, 1, 0, hi * 4 + st, "R2");
                    step(1, 1, 1, 0, "R6");
                    step(1, 1, 0, 0, "R6");
                end
        end

        // R6: single-rate wrap after five continues
        ilv = 1'b0;
        step(0, 1, 1, 13, "R6");
        for (int c = 0; c < 5; c++) step(1, 1, 1, 0, "R6");

        // R8: write right after read, then after one idle, then after two
        step(0, 0, 1, 5, "R8");
        nop(2);
        step(0, 1, 1, 7, "R8");
        nop(1);
        step(0, 0, 1, 9, "R8");
        step(0, 1, 1, 9, "R4");
        nop(2);
        step(0, 0, 1, 10, "R8");
        nop(2);

        // R4: double-rate write burst read back at once (array and bypass)
        ilv = 1'b1;
        step(0, 0, 0, 22, "R3");
        step(1, 1, 1, 0, "R3");
        step(0, 1, 0, 22, "R4");
        step(1, 1, 1, 0, "R4");
        nop(2);
        ilv = 1'b0;
        step(0, 0, 0, 33, "R3");
        step(1, 1, 0, 0, "R3");
        step(0, 1, 0, 33, "R4");
        step(1, 1, 0, 0, "R4");
        nop(2);

        // R4: single write bypass, then committed by a later write
        step(0, 0, 1, 40, "R4");
        step(0, 1, 1, 40, "R4");
        nop(2);
        step(0, 0, 1, 41, "R4");
        step(0, 1, 1, 40, "R4");
        step(0, 1, 1, 41, "R4");
        nop(2);

        // R9: continue after idle is rejected and drives nothing (R7)
        step(1, 1, 1, 0, "R9");
        step(1, 1, 0, 0, "R9");
        nop(1);
        step(0, 1, 1, 40, "R1");
        step(1, 1, 1, 0, "R1");
        nop(3);

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

endmodule